// File: doc/BRIEF.md
# Banked Memory Mapping Controller

This block turns a cartridge's small program and pattern address windows into physical bank numbers for a console with an 8-bit processor. Software programs it with writes to the upper half of processor space (0x8000–0xFFFF). One write picks a target register and two mode bits. A following write fills the target with a bank number. A third register location sets how the nametables are mirrored.

Every cycle, the block maps the processor address onto one of four 8 KB program windows. It also maps the video address onto one of eight 1 KB pattern windows. The outputs are the physical bank numbers, which the surrounding logic joins with the low address bits. The block also flags processor accesses to the program-RAM window. When the board is strapped for four independent screens, it flags video accesses to the extra nametable RAM.

The ROM and RAM arrays, the scanline interrupt counter and the video chip are not part of this block. The number of program and pattern banks are parameters. A bank number past the end wraps modulo the bank count.

Top module: `bankmap_ctrl`

## Requirements
- R1: After reset, the target field, both mode bits and all eight bank registers are zero, and mirroring is vertical (`mirror_horiz`=0). The program windows then map to 0, 0, PRG_BANKS-2 and PRG_BANKS-1. The pattern windows 0–7 map to 0, 1, 0, 1, 0, 0, 0, 0.
- R2: A write is decoded from cpu_addr[15], cpu_addr[14:13] and cpu_addr[0]. The other address bits are ignored.
  - {1,00,0} is bank-select: data bits [2:0] give the target register, bit 6 is the program swap and bit 7 is the pattern inversion.
  - {1,00,1} is bank-data.
  - {1,01,0} is mirroring.
  - Writes at {1,01,1}, {1,10,x} and {1,11,x} change no mapping.
- R3: A bank-data write stores cpu_data into the bank register numbered by the current target field. The new value is visible at the outputs from the next cycle on.
- R4: With the program swap clear, the windows at 0x8000, 0xA000 and 0xC000 map to register 6, register 7 and bank PRG_BANKS-2.
- R5: With the program swap set, the windows at 0x8000, 0xA000 and 0xC000 map to bank PRG_BANKS-2, register 7 and register 6.
- R6: The window at 0xE000 always maps to bank PRG_BANKS-1.
- R7: With inversion clear, the pattern windows map as follows:
  - Windows 0/1 get register 0 with bit 0 cleared, plus 0 and plus 1.
  - Windows 2/3 get register 1 the same way.
  - Windows 4–7 get registers 2–5.
  - The window index is ppu_addr[12:10].
- R8: With inversion set, windows 0–3 get registers 2–5. Windows 4/5 and 6/7 get the 2 KB pairs from registers 0 and 1.
- R9: A mirroring write sets `mirror_horiz` to cpu_data[0] (0 vertical, 1 horizontal). It has no effect while `four_screen` is 1.
- R10: Every bank number taken from a register is reduced modulo the bank count (PRG_BANKS or CHR_BANKS) after the bit 0 clearing and window offset.
- R11: `prg_ram_sel` is 1 exactly for cpu_addr 0x6000–0x7FFF. `exram_sel` is 1 exactly when `four_screen` is 1 and ppu_addr is in 0x2000–0x3EFF.
- R12: A write with cpu_addr[15]=0 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor address |
| cpu_data | input | 8 | Processor write data |
| cpu_wr | input | 1 | Processor write strobe, sampled on the clock edge |
| ppu_addr | input | 14 | Video address |
| four_screen | input | 1 | Board strap for four independent nametables |
| prg_bank | output | $clog2(PRG_BANKS) | Physical 8 KB program bank for cpu_addr |
| chr_bank | output | $clog2(CHR_BANKS) | Physical 1 KB pattern bank for ppu_addr |
| mirror_horiz | output | 1 | Mirroring select: 0 vertical, 1 horizontal |
| prg_ram_sel | output | 1 | Processor address is in the program-RAM window |
| exram_sel | output | 1 | Video address goes to the extra nametable RAM |

## Verification
A register write and a translation through that register can fall in the same cycle. During a write cycle, the address lines both carry the register location and drive a live program lookup. The mode and bank outputs must keep the old mapping until the clock edge and switch to the new one on the following cycle. The bench exercises this with random writes that mix the target field, both mode bits and the four-screen strap. After every write, it sweeps all program and pattern windows and compares each against a model of the register state, updated only on the edge. It also places bank-select writes at aliased addresses, where the masked decode must still treat them as bank-select.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;

  localparam int unsigned NUM_BANK_REGS = 8;
  localparam int unsigned TGT_W = $clog2(NUM_BANK_REGS);

  typedef enum logic [1:0] {
    SLOT_SELECT,
    SLOT_DATA,
    SLOT_MIRROR,
    SLOT_NONE
  } reg_slot_e;

  // Decode of the write location: bit 15, bits 14:13 and bit 0 take part.
  function automatic reg_slot_e decode_slot(logic top, logic [1:0] mid, logic lsb);
    if (!top) return SLOT_NONE;
    case ({mid, lsb})
      3'b000:  return SLOT_SELECT;
      3'b001:  return SLOT_DATA;
      3'b010:  return SLOT_MIRROR;
      default: return SLOT_NONE;
    endcase
  endfunction

  // Program window 0..3 (0x8000, 0xA000, 0xC000, 0xE000) to a physical bank.
  function automatic int unsigned prg_window_bank(logic [1:0] win, logic swap,
                                                  logic [7:0] r6, logic [7:0] r7,
                                                  int unsigned n);
    int unsigned lo;
    int unsigned hi;
    lo = 32'(r6) % n;
    hi = 32'(r7) % n;
    case (win)
      2'd0:    return swap ? (n - 2) : lo;
      2'd1:    return hi;
      2'd2:    return swap ? lo : (n - 2);
      default: return n - 1;
    endcase
  endfunction

  // Pattern window 0..7 to a physical bank; inversion swaps the two halves.
  function automatic int unsigned chr_window_bank(logic [2:0] win, logic inv,
                                                  logic [NUM_BANK_REGS-1:0][7:0] regs,
                                                  int unsigned n);
    logic [2:0] w;
    logic [7:0] v;
    w = win ^ {inv, 2'b00};
    if (!w[2]) v = {regs[{2'b00, w[1]}][7:1], w[0]};
    else       v = regs[3'd2 + {1'b0, w[1:0]}];
    return 32'(v) % n;
  endfunction

endpackage

// File: rtl/bankmap_regs.sv
module bankmap_regs
  import bankmap_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            addr_top,
  input  logic [1:0]                      addr_mid,
  input  logic                            addr_lsb,
  input  logic [7:0]                      cpu_data,
  input  logic                            cpu_wr,
  input  logic                            four_screen,
  output logic [TGT_W-1:0]                tgt_q,
  output logic                            prg_swap_q,
  output logic                            chr_inv_q,
  output logic [NUM_BANK_REGS-1:0][7:0]   bank_q,
  output logic                            mirror_h_q
);

  reg_slot_e slot;
  logic      wr_select;
  logic      wr_data;
  logic      wr_mirror;

  assign slot      = decode_slot(addr_top, addr_mid, addr_lsb);
  assign wr_select = cpu_wr && (slot == SLOT_SELECT);
  assign wr_data   = cpu_wr && (slot == SLOT_DATA);
  assign wr_mirror = cpu_wr && (slot == SLOT_MIRROR) && !four_screen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q      <= '0;
      prg_swap_q <= 1'b0;
      chr_inv_q  <= 1'b0;
      bank_q     <= '0;
      mirror_h_q <= 1'b0;
    end else begin
      if (wr_select) begin
        tgt_q      <= cpu_data[TGT_W-1:0];
        prg_swap_q <= cpu_data[6];
        chr_inv_q  <= cpu_data[7];
      end
      if (wr_data)   bank_q[tgt_q] <= cpu_data;
      if (wr_mirror) mirror_h_q    <= cpu_data[0];
    end
  end

  p_data_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && addr_top && addr_mid == 2'b00 && addr_lsb)
      |=> bank_q[$past(tgt_q)] == $past(cpu_data));

  p_mirror_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && addr_top && addr_mid == 2'b01 && !addr_lsb && !four_screen)
      |=> mirror_h_q == $past(cpu_data[0]));

  p_mirror_strap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && four_screen) |=> $stable(mirror_h_q));

  p_lower_half_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !addr_top)
      |=> ($stable(bank_q) && $stable(tgt_q) && $stable(prg_swap_q)
           && $stable(chr_inv_q) && $stable(mirror_h_q)));

endmodule

// File: rtl/bankmap_prg_xlate.sv
module bankmap_prg_xlate
  import bankmap_pkg::*;
#(
  parameter int unsigned PRG_BANKS = 24,
  localparam int unsigned PW = $clog2(PRG_BANKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    win,
  input  logic          swap,
  input  logic [7:0]    r6,
  input  logic [7:0]    r7,
  output logic [PW-1:0] bank
);

  assign bank = PW'(prg_window_bank(win, swap, r6, r7, PRG_BANKS));

  p_last_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (win == 2'd3) |-> bank == PW'(PRG_BANKS - 1));

  p_swap_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (swap && win == 2'd0) |-> bank == PW'(PRG_BANKS - 2));

  p_prg_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    32'(bank) < PRG_BANKS);

endmodule

// File: rtl/bankmap_chr_xlate.sv
module bankmap_chr_xlate
  import bankmap_pkg::*;
#(
  parameter int unsigned CHR_BANKS = 200,
  localparam int unsigned CW = $clog2(CHR_BANKS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [2:0]                    win,
  input  logic                          inv,
  input  logic [NUM_BANK_REGS-1:0][7:0] regs,
  output logic [CW-1:0]                 bank
);

  assign bank = CW'(chr_window_bank(win, inv, regs, CHR_BANKS));

  p_chr_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    32'(bank) < CHR_BANKS);

endmodule

// File: rtl/bankmap_ctrl.sv
module bankmap_ctrl
  import bankmap_pkg::*;
#(
  parameter int unsigned PRG_BANKS = 24,
  parameter int unsigned CHR_BANKS = 200
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [15:0]                  cpu_addr,
  input  logic [7:0]                   cpu_data,
  input  logic                         cpu_wr,
  input  logic [13:0]                  ppu_addr,
  input  logic                         four_screen,
  output logic [$clog2(PRG_BANKS)-1:0] prg_bank,
  output logic [$clog2(CHR_BANKS)-1:0] chr_bank,
  output logic                         mirror_horiz,
  output logic                         prg_ram_sel,
  output logic                         exram_sel
);

  logic [TGT_W-1:0]              tgt_q;
  logic                          prg_swap_q;
  logic                          chr_inv_q;
  logic [NUM_BANK_REGS-1:0][7:0] bank_q;
  logic                          unused_addr_bits;

  assign unused_addr_bits = ^{cpu_addr[12:1], ppu_addr[9:0]};

  bankmap_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_top   (cpu_addr[15]),
    .addr_mid   (cpu_addr[14:13]),
    .addr_lsb   (cpu_addr[0]),
    .cpu_data   (cpu_data),
    .cpu_wr     (cpu_wr),
    .four_screen(four_screen),
    .tgt_q      (tgt_q),
    .prg_swap_q (prg_swap_q),
    .chr_inv_q  (chr_inv_q),
    .bank_q     (bank_q),
    .mirror_h_q (mirror_horiz)
  );

  bankmap_prg_xlate #(.PRG_BANKS(PRG_BANKS)) u_prg (
    .clk  (clk),
    .rst_n(rst_n),
    .win  (cpu_addr[14:13]),
    .swap (prg_swap_q),
    .r6   (bank_q[6]),
    .r7   (bank_q[7]),
    .bank (prg_bank)
  );

  bankmap_chr_xlate #(.CHR_BANKS(CHR_BANKS)) u_chr (
    .clk  (clk),
    .rst_n(rst_n),
    .win  (ppu_addr[12:10]),
    .inv  (chr_inv_q),
    .regs (bank_q),
    .bank (chr_bank)
  );

  assign prg_ram_sel = (cpu_addr[15:13] == 3'b011);
  assign exram_sel   = four_screen && ppu_addr[13] && (ppu_addr[12:8] != 5'h1F);

  p_exram_strap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    exram_sel |-> four_screen);

  p_ram_not_rom_r11: assert property (@(posedge clk) disable iff (!rst_n)
    prg_ram_sel |-> !cpu_addr[15]);

endmodule

// File: tb/bankmap_ctrl_test.sv
`timescale 1ns/100ps
module bankmap_ctrl_test;

  localparam int unsigned PRG_N = 24;
  localparam int unsigned CHR_N = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        cpu_wr = 1'b0;
  logic [13:0] ppu_addr = '0;
  logic        four_screen = 1'b0;
  logic [$clog2(PRG_N)-1:0] prg_bank;
  logic [$clog2(CHR_N)-1:0] chr_bank;
  logic        mirror_horiz;
  logic        prg_ram_sel;
  logic        exram_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] m_sel;
  logic [7:0] m_reg [8];
  logic       m_mir;

  bankmap_ctrl #(.PRG_BANKS(PRG_N), .CHR_BANKS(CHR_N)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .four_screen(four_screen),
    .prg_bank(prg_bank), .chr_bank(chr_bank), .mirror_horiz(mirror_horiz),
    .prg_ram_sel(prg_ram_sel), .exram_sel(exram_sel)
  );

  always #2 clk = ~clk;

  function automatic int exp_prg(int win);
    int lo = int'(m_reg[6]) % PRG_N;
    int hi = int'(m_reg[7]) % PRG_N;
    if (win == 3) return PRG_N - 1;
    if (win == 1) return hi;
    if (win == 0) return m_sel[6] ? PRG_N - 2 : lo;
    return m_sel[6] ? lo : PRG_N - 2;
  endfunction

  function automatic int exp_chr(int win);
    int w = m_sel[7] ? (win ^ 4) : win;
    int v;
    if (w < 4) v = (int'(m_reg[w / 2]) & 'hFE) + (w % 2);
    else       v = int'(m_reg[2 + (w - 4)]);
    return v % CHR_N;
  endfunction

  task automatic chk(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_write(logic [15:0] a, logic [7:0] d);
    if (a[15]) begin
      case ({a[14:13], a[0]})
        3'b000: m_sel = d;
        3'b001: m_reg[m_sel[2:0]] = d;
        3'b010: if (!four_screen) m_mir = d[0];
        default: ;
      endcase
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
    model_write(a, d);
  endtask

  task automatic sweep(string force_tag);
    string t;
    for (int win = 0; win < 4; win++) begin
      cpu_addr = 16'h8000 | 16'(win << 13) | 16'($urandom % 16'h2000);
      #0.1;
      if (force_tag != "") t = force_tag;
      else if (win == 3) t = "R6";
      else t = m_sel[6] ? "R5" : "R4";
      chk(t, int'(prg_bank), exp_prg(win), $sformatf("prg window %0d", win));
    end
    for (int win = 0; win < 8; win++) begin
      ppu_addr = 14'(win << 10) | 14'($urandom % 1024);
      #0.1;
      if (force_tag != "") t = force_tag;
      else t = m_sel[7] ? "R8" : "R7";
      chk(t, int'(chr_bank), exp_chr(win), $sformatf("chr window %0d", win));
    end
    chk(force_tag != "" ? force_tag : "R9", int'(mirror_horiz), int'(m_mir), "mirroring");
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_sel = '0; m_mir = 1'b0;
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    sweep("R1");

    // R3 and R4: fill every register, default modes
    for (int i = 0; i < 8; i++) begin
      wr(16'h8000, 8'(i));
      wr(16'h8001, 8'(3 + 2 * i));
    end
    sweep("R3");
    sweep("");

    // R2: aliased bank-select location sets both mode bits
    wr(16'h9FFE, 8'hC6);
    sweep("R2");
    // R2: unused slots leave everything alone
    wr(16'hA001, 8'hFF);
    wr(16'hC000, 8'h3F);
    wr(16'hE001, 8'h01);
    sweep("R2");

    // R12: lower half writes ignored
    wr(16'h6000, 8'h07);
    wr(16'h0001, 8'hAA);
    wr(16'h2000, 8'h01);
    sweep("R12");

    // R9: mirroring set, cleared, and blocked by strap
    wr(16'hA000, 8'h01);
    chk("R9", int'(mirror_horiz), 1, "set horizontal");
    four_screen = 1'b1;
    wr(16'hA000, 8'h00);
    chk("R9", int'(mirror_horiz), 1, "strap blocks write");
    four_screen = 1'b0;
    wr(16'hBFFE, 8'h00);
    chk("R9", int'(mirror_horiz), 0, "set vertical");

    // R10: wrap of out-of-range numbers
    wr(16'h8000, 8'h06);
    wr(16'h8001, 8'd30);
    cpu_addr = 16'h8123; #0.1;
    chk("R10", int'(prg_bank), 6, "prg 30 mod 24");
    wr(16'h8000, 8'h02);
    wr(16'h8001, 8'd250);
    ppu_addr = 14'h1000; #0.1;
    chk("R10", int'(chr_bank), 50, "chr 250 mod 200");
    wr(16'h8000, 8'h00);
    wr(16'h8001, 8'd255);
    ppu_addr = 14'h0400; #0.1;
    chk("R10", int'(chr_bank), 55, "chr pair 254+1 mod 200");

    // R11: window flags
    cpu_addr = 16'h6000; #0.1; chk("R11", int'(prg_ram_sel), 1, "ram 0x6000");
    cpu_addr = 16'h7FFF; #0.1; chk("R11", int'(prg_ram_sel), 1, "ram 0x7FFF");
    cpu_addr = 16'h5FFF; #0.1; chk("R11", int'(prg_ram_sel), 0, "ram 0x5FFF");
    cpu_addr = 16'h8000; #0.1; chk("R11", int'(prg_ram_sel), 0, "ram 0x8000");
    four_screen = 1'b1;
    ppu_addr = 14'h2000; #0.1; chk("R11", int'(exram_sel), 1, "exram 0x2000");
    ppu_addr = 14'h3EFF; #0.1; chk("R11", int'(exram_sel), 1, "exram 0x3EFF");
    ppu_addr = 14'h3F00; #0.1; chk("R11", int'(exram_sel), 0, "exram 0x3F00");
    ppu_addr = 14'h1FFF; #0.1; chk("R11", int'(exram_sel), 0, "exram 0x1FFF");
    four_screen = 1'b0;
    ppu_addr = 14'h2400; #0.1; chk("R11", int'(exram_sel), 0, "exram no strap");

    // Random mix of writes, modes and strap
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      a = 16'($urandom);
      if (($urandom % 10) != 0) a[15] = 1'b1;
      if (($urandom % 32) == 0) four_screen = ~four_screen;
      wr(a, 8'($urandom));
      sweep("");
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule